// File: doc/BRIEF.md
# Background Way Maintenance Engine

This block applies one of three maintenance actions to whole ways of a set-associative cache: invalidate, clean, or clean-and-invalidate. It runs them as a background task. Software starts an action by writing a way-select mask to one of three operation addresses. The engine then visits every index of each selected way. It works through the ways from the lowest set bit upward and through the indices in ascending order. As each way finishes, the engine clears that way's bit. Reading any of the three operation addresses returns the mask that is still pending, so software polls until the mask reads zero.

The line state (valid, dirty, non-secure flag and tag) is held in a small internal array. A fill port models allocation, a lookup port models hits, and a peek port exposes the stored state of one line. While the engine is busy, the pending mask also acts as a lock on those ways. Fills into a locked way are refused, but lookups still hit in it. Every register write that arrives while the engine is busy is refused with an error response. Dirty lines leave the block through a request/acknowledge writeback handshake.

A write that sets `reg_wr_secure` affects every line in the selected ways. A write without it affects only lines whose non-secure flag is set, and leaves all other lines untouched.

Top module: `wme_engine`

## Requirements
- R1: A write while idle to offset 0x77C (invalidate), 0x7BC (clean) or 0x7FC (clean-and-invalidate) loads the pending mask from `reg_wr_data[NUM_WAYS-1:0]`. With 8 ways, data bits [15:8] are reserved and ignored. A read at any of the three offsets returns the pending mask in bits [NUM_WAYS-1:0], with zeros above; a read at any other offset returns zero.
- R2: Invalidate clears valid and dirty on every affected line of the selected ways and issues no writeback. Selecting all ways invalidates the whole cache.
- R3: Clean writes back each affected line that is valid and dirty, then clears its dirty bit and leaves its valid bit set.
- R4: Clean-and-invalidate writes back each affected valid and dirty line, then clears valid and dirty on every affected line.
- R5: A write with `reg_wr_secure`=1 affects all lines. A write with `reg_wr_secure`=0 affects only lines whose non-secure flag is 1; all other lines keep their state and produce no writeback.
- R6: Ways are processed in ascending order and indices in ascending order within a way. A way's mask bit clears in the cycle after its last index is handled, so lower ways leave the mask first. The engine never sets a mask bit except on an accepted start.
- R7: `lock_mask` equals the pending mask. A fill into a locked way is refused (`fill_ok`=0) and leaves the line unchanged. A lookup still hits in a locked way, and a write lookup that hits sets the line's dirty bit.
- R8: Any register write while the engine is busy raises `reg_wr_err` in the same cycle and does not change the pending mask.
- R9: `wb_req` stays high, with its index and way stable, until `wb_ack` is seen. Writebacks occur only for lines in a locked way.
- R10: After reset the pending mask is zero, no way is locked, `wb_req` is low and every line is invalid.
- R11: While idle, a write of an all-zero mask, or a write to any other offset, starts nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_wr_secure | input | 1 | 1 = secure write |
| reg_wr_err | output | 1 | Error response for the current write |
| reg_rd_addr | input | 12 | Register read offset |
| reg_rd_data | output | 32 | Register read data |
| lock_mask | output | NUM_WAYS | Ways closed to allocation |
| fill_en | input | 1 | Allocation request |
| fill_index | input | IDX_W | Index to fill |
| fill_way | input | WAY_W | Way to fill |
| fill_tag | input | TAG_W | Tag to store |
| fill_valid | input | 1 | Valid bit to store |
| fill_dirty | input | 1 | Dirty bit to store |
| fill_ns | input | 1 | Non-secure flag to store |
| fill_ok | output | 1 | Fill accepted |
| lk_en | input | 1 | Lookup request |
| lk_wr | input | 1 | Lookup is a write (sets dirty on a hit) |
| lk_index | input | IDX_W | Lookup index |
| lk_tag | input | TAG_W | Lookup tag |
| lk_ns | input | 1 | Lookup non-secure flag |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Lowest hitting way |
| pk_index | input | IDX_W | Peek index |
| pk_way | input | WAY_W | Peek way |
| pk_valid | output | 1 | Valid bit of the peeked line |
| pk_dirty | output | 1 | Dirty bit of the peeked line |
| pk_ns | output | 1 | Non-secure flag of the peeked line |
| pk_tag | output | TAG_W | Tag of the peeked line |
| wb_req | output | 1 | Writeback request |
| wb_index | output | IDX_W | Index of the line being written back |
| wb_way | output | WAY_W | Way of the line being written back |
| wb_tag | output | TAG_W | Tag of the line being written back |
| wb_ns | output | 1 | Non-secure flag of the line being written back |
| wb_ack | input | 1 | Writeback accepted |

## Verification
The assertions check, on every cycle, that the writeback request holds steady until it is acknowledged and that it only targets a locked way. They also check that this way is the lowest way still pending. A further assertion checks that mask bits only ever drop, both with no write and with a write refused while busy. The per-line results of each action under each security setting can only be shown by the bench's scenarios, which fill the array with computed patterns and compare every line afterward. The same holds for the writeback counts, the ignored reserved bits, fill refusal and hits in locked ways, the error response, and the order in which ways leave the mask.

// File: rtl/wme_pkg.sv
package wme_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_INV   = 2'd1,
      OP_CLEAN = 2'd2,
      OP_CINV  = 2'd3
   } maint_op_e;

   typedef struct packed {
      logic valid;
      logic dirty;
      logic ns;
   } line_st_t;

   localparam logic [11:0] OFS_INV   = 12'h77C;
   localparam logic [11:0] OFS_CLEAN = 12'h7BC;
   localparam logic [11:0] OFS_CINV  = 12'h7FC;

   function automatic maint_op_e decode_op(input logic [11:0] ofs);
      case (ofs)
         OFS_INV:   return OP_INV;
         OFS_CLEAN: return OP_CLEAN;
         OFS_CINV:  return OP_CINV;
         default:   return OP_NONE;
      endcase
   endfunction

endpackage

// File: rtl/wme_way_pick.sv
module wme_way_pick #(
   parameter int N   = 8,
   localparam int W  = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] first,
   output logic         any
);
   always_comb begin
      first = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) first = W'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/wme_tag_array.sv
module wme_tag_array
   import wme_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int NUM_WAYS = 8,
   parameter int TAG_W    = 8,
   localparam int IDX_W   = $clog2(NUM_SETS),
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   // engine port
   input  logic [IDX_W-1:0] e_idx,
   input  logic [WAY_W-1:0] e_way,
   output line_st_t         e_st,
   output logic [TAG_W-1:0] e_tag,
   input  logic             e_we,
   input  line_st_t         e_st_new,
   // fill port (already gated by lock)
   input  logic             f_we,
   input  logic [IDX_W-1:0] f_idx,
   input  logic [WAY_W-1:0] f_way,
   input  logic [TAG_W-1:0] f_tag,
   input  line_st_t         f_st,
   // lookup port
   input  logic             h_en,
   input  logic             h_wr,
   input  logic [IDX_W-1:0] h_idx,
   input  logic [TAG_W-1:0] h_tag,
   input  logic             h_ns,
   output logic             h_hit,
   output logic [WAY_W-1:0] h_way,
   // peek port
   input  logic [IDX_W-1:0] p_idx,
   input  logic [WAY_W-1:0] p_way,
   output line_st_t         p_st,
   output logic [TAG_W-1:0] p_tag
);
   line_st_t         st_q  [NUM_SETS][NUM_WAYS];
   logic [TAG_W-1:0] tag_q [NUM_SETS][NUM_WAYS];
   logic [NUM_WAYS-1:0] hit_vec;

   assign e_st  = st_q[e_idx][e_way];
   assign e_tag = tag_q[e_idx][e_way];
   assign p_st  = st_q[p_idx][p_way];
   assign p_tag = tag_q[p_idx][p_way];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      assign hit_vec[w] = h_en && st_q[h_idx][w].valid &&
                          (tag_q[h_idx][w] == h_tag) && (st_q[h_idx][w].ns == h_ns);
   end

   wme_way_pick #(.N(NUM_WAYS)) u_hit_pick (
      .vec   (hit_vec),
      .first (h_way),
      .any   (h_hit)
   );

   // state: write hit < fill < engine (last assignment wins)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
               st_q[s][w] <= '0;
            end
         end
      end else begin
         if (h_wr && h_hit) st_q[h_idx][h_way].dirty <= 1'b1;
         if (f_we)          st_q[f_idx][f_way]       <= f_st;
         if (e_we)          st_q[e_idx][e_way]       <= e_st_new;
      end
   end

   always_ff @(posedge clk) begin
      if (f_we) tag_q[f_idx][f_way] <= f_tag;
   end
endmodule

// File: rtl/wme_sequencer.sv
module wme_sequencer
   import wme_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int NUM_WAYS = 8,
   localparam int IDX_W   = $clog2(NUM_SETS),
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  maint_op_e           start_op,
   input  logic [NUM_WAYS-1:0] start_mask,
   input  logic                start_sec,
   input  line_st_t            line_st,
   input  logic                wb_ack,
   output logic [NUM_WAYS-1:0] mask_q,
   output logic [WAY_W-1:0]    cur_way,
   output logic [IDX_W-1:0]    idx_q,
   output logic                upd_we,
   output line_st_t            upd_st,
   output logic                wb_req,
   output logic                busy
);
   typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WB, ST_NEXT} seq_st_e;

   seq_st_e             state_q;
   maint_op_e           op_q;
   logic                sec_q;
   logic                elig, need_wb, step, last_idx, any_way;
   logic [NUM_WAYS-1:0] way_bit, rest;

   wme_way_pick #(.N(NUM_WAYS)) u_way_pick (
      .vec   (mask_q),
      .first (cur_way),
      .any   (any_way)
   );

   assign way_bit  = NUM_WAYS'(1) << cur_way;
   assign rest     = mask_q & ~way_bit;
   assign last_idx = (idx_q == IDX_W'(NUM_SETS - 1));
   assign busy     = (state_q != ST_IDLE);
   assign wb_req   = (state_q == ST_WB);

   always_comb begin
      elig    = sec_q | line_st.ns;
      need_wb = elig && line_st.valid && line_st.dirty && (op_q != OP_INV);
      upd_st  = line_st;
      case (op_q)
         OP_INV, OP_CINV: begin
            upd_st.valid = 1'b0;
            upd_st.dirty = 1'b0;
         end
         OP_CLEAN: upd_st.dirty = 1'b0;
         default: ;
      endcase
      step   = ((state_q == ST_SCAN) && !need_wb) || ((state_q == ST_WB) && wb_ack);
      upd_we = step && elig && any_way;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_NONE;
         sec_q   <= 1'b0;
         mask_q  <= '0;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start && (|start_mask)) begin
                  mask_q  <= start_mask;
                  op_q    <= start_op;
                  sec_q   <= start_sec;
                  idx_q   <= '0;
                  state_q <= ST_SCAN;
               end
            end
            ST_SCAN, ST_WB: begin
               if ((state_q == ST_SCAN) && need_wb) begin
                  state_q <= ST_WB;
               end else if (step) begin
                  if (last_idx) begin
                     state_q <= ST_NEXT;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_SCAN;
                  end
               end
            end
            ST_NEXT: begin
               mask_q  <= rest;
               idx_q   <= '0;
               state_q <= (|rest) ? ST_SCAN : ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wme_engine.sv
module wme_engine
   import wme_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int NUM_WAYS = 8,
   parameter int TAG_W    = 8,
   localparam int IDX_W   = $clog2(NUM_SETS),
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr_en,
   input  logic [11:0]         reg_wr_addr,
   input  logic [31:0]         reg_wr_data,
   input  logic                reg_wr_secure,
   output logic                reg_wr_err,
   input  logic [11:0]         reg_rd_addr,
   output logic [31:0]         reg_rd_data,
   output logic [NUM_WAYS-1:0] lock_mask,
   input  logic                fill_en,
   input  logic [IDX_W-1:0]    fill_index,
   input  logic [WAY_W-1:0]    fill_way,
   input  logic [TAG_W-1:0]    fill_tag,
   input  logic                fill_valid,
   input  logic                fill_dirty,
   input  logic                fill_ns,
   output logic                fill_ok,
   input  logic                lk_en,
   input  logic                lk_wr,
   input  logic [IDX_W-1:0]    lk_index,
   input  logic [TAG_W-1:0]    lk_tag,
   input  logic                lk_ns,
   output logic                lk_hit,
   output logic [WAY_W-1:0]    lk_way,
   input  logic [IDX_W-1:0]    pk_index,
   input  logic [WAY_W-1:0]    pk_way,
   output logic                pk_valid,
   output logic                pk_dirty,
   output logic                pk_ns,
   output logic [TAG_W-1:0]    pk_tag,
   output logic                wb_req,
   output logic [IDX_W-1:0]    wb_index,
   output logic [WAY_W-1:0]    wb_way,
   output logic [TAG_W-1:0]    wb_tag,
   output logic                wb_ns,
   input  logic                wb_ack
);
   if (!(NUM_WAYS == 8 || NUM_WAYS == 16)) begin : g_bad_ways
      $error("wme_engine: NUM_WAYS must be 8 or 16");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("wme_engine: NUM_SETS must be a power of two >= 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wme_engine: TAG_W must be positive");
   end

   maint_op_e           wr_op, rd_op;
   logic                busy, start, upd_we;
   logic [NUM_WAYS-1:0] cap_mask, mask_q;
   logic [IDX_W-1:0]    idx_q;
   logic [WAY_W-1:0]    cur_way;
   line_st_t            cur_st, upd_st, fill_st, pk_st;
   logic [TAG_W-1:0]    cur_tag;
   logic                unused_wr_hi;

   // mask capture width follows the way count; upper bits are reserved
   if (NUM_WAYS == 16) begin : g_cap16
      assign cap_mask     = reg_wr_data[15:0];
      assign unused_wr_hi = ^reg_wr_data[31:16];
   end else begin : g_cap8
      assign cap_mask     = reg_wr_data[7:0];
      assign unused_wr_hi = ^reg_wr_data[31:8];
   end

   assign wr_op       = decode_op(reg_wr_addr);
   assign rd_op       = decode_op(reg_rd_addr);
   assign start       = reg_wr_en && !busy && (wr_op != OP_NONE);
   assign reg_wr_err  = reg_wr_en && busy;
   assign reg_rd_data = (rd_op != OP_NONE) ? 32'(mask_q) : 32'd0;
   assign lock_mask   = mask_q;

   assign fill_ok = fill_en && !mask_q[fill_way];
   assign fill_st = '{valid: fill_valid, dirty: fill_dirty, ns: fill_ns};

   wme_sequencer #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_op   (wr_op),
      .start_mask (cap_mask),
      .start_sec  (reg_wr_secure),
      .line_st    (cur_st),
      .wb_ack     (wb_ack),
      .mask_q     (mask_q),
      .cur_way    (cur_way),
      .idx_q      (idx_q),
      .upd_we     (upd_we),
      .upd_st     (upd_st),
      .wb_req     (wb_req),
      .busy       (busy)
   );

   wme_tag_array #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .e_idx    (idx_q),
      .e_way    (cur_way),
      .e_st     (cur_st),
      .e_tag    (cur_tag),
      .e_we     (upd_we),
      .e_st_new (upd_st),
      .f_we     (fill_ok),
      .f_idx    (fill_index),
      .f_way    (fill_way),
      .f_tag    (fill_tag),
      .f_st     (fill_st),
      .h_en     (lk_en),
      .h_wr     (lk_wr),
      .h_idx    (lk_index),
      .h_tag    (lk_tag),
      .h_ns     (lk_ns),
      .h_hit    (lk_hit),
      .h_way    (lk_way),
      .p_idx    (pk_index),
      .p_way    (pk_way),
      .p_st     (pk_st),
      .p_tag    (pk_tag)
   );

   assign pk_valid = pk_st.valid;
   assign pk_dirty = pk_st.dirty;
   assign pk_ns    = pk_st.ns;
   assign wb_index = idx_q;
   assign wb_way   = cur_way;
   assign wb_tag   = cur_tag;
   assign wb_ns    = cur_st.ns;
endmodule

// File: rtl/wme_engine_chk.sv
module wme_engine_chk #(
   parameter int NUM_SETS = 16,
   parameter int NUM_WAYS = 8,
   localparam int IDX_W   = $clog2(NUM_SETS),
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr_en,
   input logic [NUM_WAYS-1:0] lock_mask,
   input logic                wb_req,
   input logic                wb_ack,
   input logic [IDX_W-1:0]    wb_index,
   input logic [WAY_W-1:0]    wb_way
);
   logic [NUM_WAYS-1:0] below_way;
   assign below_way = (NUM_WAYS'(1) << wb_way) - NUM_WAYS'(1);

   assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && !wb_ack) |=> (wb_req && $stable(wb_index) && $stable(wb_way)));

   assert_wb_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> lock_mask[wb_way]);

   assert_lowest_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> ((lock_mask & below_way) == '0));

   assert_no_new_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_en |=> ((lock_mask & ~$past(lock_mask)) == '0));

   assert_busy_write_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && (lock_mask != '0)) |=> ((lock_mask & ~$past(lock_mask)) == '0));
endmodule

bind wme_engine wme_engine_chk #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_wme_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr_en (reg_wr_en),
   .lock_mask (lock_mask),
   .wb_req    (wb_req),
   .wb_ack    (wb_ack),
   .wb_index  (wb_index),
   .wb_way    (wb_way)
);

// File: tb/wme_engine_tb_top.sv
module wme_engine_tb_top;
   localparam int NS = 16;
   localparam int NW = 8;
   localparam int TW = 8;
   localparam int IW = $clog2(NS);
   localparam int WW = $clog2(NW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic          reg_wr_en = 0, reg_wr_secure = 0, reg_wr_err;
   logic [11:0]   reg_wr_addr = 0, reg_rd_addr = 0;
   logic [31:0]   reg_wr_data = 0, reg_rd_data;
   logic [NW-1:0] lock_mask;
   logic          fill_en = 0, fill_valid = 0, fill_dirty = 0, fill_ns = 0, fill_ok;
   logic [IW-1:0] fill_index = 0, lk_index = 0, pk_index = 0, wb_index;
   logic [WW-1:0] fill_way = 0, pk_way = 0, lk_way, wb_way;
   logic [TW-1:0] fill_tag = 0, lk_tag = 0, pk_tag, wb_tag;
   logic          lk_en = 0, lk_wr = 0, lk_ns = 0, lk_hit;
   logic          pk_valid, pk_dirty, pk_ns;
   logic          wb_req, wb_ns, wb_ack = 0;

   wme_engine #(.NUM_SETS(NS), .NUM_WAYS(NW), .TAG_W(TW)) dut_i (.*);

   int n_chk = 0, n_err = 0;
   bit finished = 0;
   int ack_dly = 0, ack_cnt = 0;
   int wb_cnt = 0, order_bad = 0, prev_way = -1, prev_idx = -1;

   // writeback responder
   always @(posedge clk) begin
      if (wb_req && !wb_ack) begin
         if (ack_cnt >= ack_dly) begin wb_ack <= 1'b1; ack_cnt <= 0; end
         else ack_cnt <= ack_cnt + 1;
      end else wb_ack <= 1'b0;
   end

   // handshake recorder (sampled mid-cycle)
   always @(negedge clk) begin
      if (rst_n && wb_req && wb_ack) begin
         wb_cnt++;
         if (int'(wb_way) < prev_way || (int'(wb_way) == prev_way && int'(wb_index) <= prev_idx))
            order_bad++;
         prev_way = int'(wb_way);
         prev_idx = int'(wb_index);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d, input logic s,
                            output logic err);
      @(negedge clk);
      reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d; reg_wr_secure = s;
      #1 err = reg_wr_err;
      @(posedge clk); #1;
      reg_wr_en = 0;
   endtask

   task automatic fill(input int s, input int w, input int tag, input logic v,
                       input logic d, input logic n, output logic ok);
      @(negedge clk);
      fill_en = 1; fill_index = IW'(s); fill_way = WW'(w); fill_tag = TW'(tag);
      fill_valid = v; fill_dirty = d; fill_ns = n;
      #1 ok = fill_ok;
      @(posedge clk); #1;
      fill_en = 0;
   endtask

   task automatic lookup(input int s, input int tag, input logic n, input logic wr,
                         output logic hit, output int way);
      @(negedge clk);
      lk_en = 1; lk_wr = wr; lk_index = IW'(s); lk_tag = TW'(tag); lk_ns = n;
      #1 hit = lk_hit; way = int'(lk_way);
      @(posedge clk); #1;
      lk_en = 0; lk_wr = 0;
   endtask

   task automatic peek(input int s, input int w, output logic [2:0] st);
      @(negedge clk);
      pk_index = IW'(s); pk_way = WW'(w);
      #1 st = {pk_valid, pk_dirty, pk_ns};
   endtask

   task automatic wait_idle(output int cycles);
      cycles = 0;
      reg_rd_addr = 12'h7BC;
      do begin
         @(negedge clk); cycles++;
      end while (reg_rd_data != 0 && cycles < 20000);
   endtask

   function automatic logic pv(int s, int w, int k); return ((s * 7 + w * 3 + k) % 4) != 0; endfunction
   function automatic logic pd(int s, int w, int k); return ((s + w * 5 + k) % 3) != 0; endfunction
   function automatic logic pn(int s, int w, int k); return ((s * 3 + w + k) % 2) == 1; endfunction

   typedef struct packed {
      logic [11:0] addr;
      logic [31:0] data;
      logic        sec;
      logic [3:0]  seed;
   } vec_t;

   // R3 clean, R4 clean+inv, R2 inv all, R5 non-secure variants, R1 reserved bits
   localparam vec_t VECS [7] = '{
      '{12'h7BC, 32'h0000_0005, 1'b1, 4'd1},
      '{12'h7FC, 32'h0000_0082, 1'b1, 4'd2},
      '{12'h77C, 32'h0000_00FF, 1'b1, 4'd3},
      '{12'h7BC, 32'h0000_003C, 1'b0, 4'd4},
      '{12'h7FC, 32'h0000_00F0, 1'b0, 4'd5},
      '{12'h77C, 32'h0000_000F, 1'b0, 4'd6},
      '{12'h7FC, 32'h0000_FF01, 1'b1, 4'd7}
   };
   localparam string VREQ [7] = '{"R3", "R4", "R2", "R5", "R5", "R5", "R1"};

   initial begin : watchdog
      #(8 * 190000);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin : main
      logic err, ok, hit;
      logic [2:0] st;
      int way, cyc, exp_wb, bad, first_change;

      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R10 reset state
      @(negedge clk);
      reg_rd_addr = 12'h77C;
      #1 chk(reg_rd_data == 0, "R10 mask after reset", reg_rd_data, 0);
      chk(lock_mask == 0 && !wb_req, "R10 lock/wb after reset", {lock_mask, wb_req}, 0);
      bad = 0;
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin
            peek(s, w, st);
            if (st[2]) bad++;
         end
      chk(bad == 0, "R10 lines invalid after reset", bad, 0);

      // R11 idle no-ops
      reg_write(12'h700, 32'hFF, 1'b1, err);
      chk(!err && lock_mask == 0, "R11 other offset idle", {err, lock_mask}, 0);
      reg_write(12'h7BC, 32'h0, 1'b1, err);
      @(negedge clk);
      chk(!err && lock_mask == 0, "R11 zero mask idle", {err, lock_mask}, 0);

      // vector table: R1..R5
      for (int k = 0; k < 7; k++) begin
         vec_t v;
         logic [NW-1:0] m;
         v = VECS[k];
         m = v.data[NW-1:0];
         ack_dly = k % 3;
         for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
               fill(s, w, s * 16 + w, pv(s, w, k), pd(s, w, k), pn(s, w, k), ok);
         wb_cnt = 0; order_bad = 0; prev_way = -1; prev_idx = -1;
         reg_write(v.addr, v.data, v.sec, err);
         @(negedge clk);
         reg_rd_addr = v.addr;
         #1 chk(reg_rd_data == 32'(m), {VREQ[k], " readback mask"}, reg_rd_data, 32'(m));
         wait_idle(cyc);
         exp_wb = 0; bad = 0;
         for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
               logic ev, ed, en, el;
               ev = pv(s, w, k); ed = pd(s, w, k); en = pn(s, w, k);
               el = v.sec || en;
               if (m[w] && el) begin
                  if (v.addr != 12'h77C && ev && ed) exp_wb++;
                  if (v.addr == 12'h7BC) ed = 0;
                  else begin ev = 0; ed = 0; end
               end
               peek(s, w, st);
               if (st != {ev, ed, en}) bad++;
            end
         chk(bad == 0, {VREQ[k], " line states"}, bad, 0);
         chk(wb_cnt == exp_wb, {VREQ[k], " writeback count"}, wb_cnt, exp_wb);
         chk(order_bad == 0, "R6 ascending order", order_bad, 0);
      end

      // R6 progress: lower way leaves mask first
      for (int s = 0; s < NS; s++) begin
         fill(s, 1, s, 1, 1, 1, ok);
         fill(s, 3, s, 1, 1, 0, ok);
      end
      ack_dly = 2;
      reg_write(12'h7BC, 32'h0A, 1'b1, err);
      first_change = 32'h0A;
      for (int c = 0; c < 5000; c++) begin
         @(negedge clk);
         if (lock_mask != 8'h0A) begin first_change = int'(lock_mask); break; end
      end
      chk(first_change == 8'h08, "R6 way 1 clears first", first_change, 8'h08);
      wait_idle(cyc);

      // R7 / R8 lock and busy behaviour
      for (int s = 0; s < NS; s++) fill(s, 2, 8'h20 + s, 1, 1, 1, ok);
      fill(0, 3, 8'h00, 0, 0, 1, ok);
      ack_dly = 40;
      wb_cnt = 0;
      reg_write(12'h7BC, 32'h04, 1'b1, err);
      @(negedge clk);
      chk(lock_mask == 8'h04, "R7 lock mask equals pending", lock_mask, 8'h04);
      fill(15, 2, 8'h55, 1, 0, 1, ok);
      chk(!ok, "R7 fill refused in locked way", ok, 0);
      lookup(15, 8'h55, 1'b1, 1'b0, hit, way);
      chk(!hit, "R7 refused fill left line unchanged", hit, 0);
      lookup(15, 8'h2F, 1'b1, 1'b0, hit, way);
      chk(hit && way == 2, "R7 hit in locked way", {hit, 8'(way)}, {1'b1, 8'd2});
      fill(0, 3, 8'h33, 1, 0, 1, ok);
      chk(ok, "R7 fill accepted in unlocked way", ok, 1);
      lookup(0, 8'h33, 1'b1, 1'b1, hit, way);
      peek(0, 3, st);
      chk(st == 3'b111, "R7 write hit sets dirty", st, 3'b111);
      reg_write(12'h7FC, 32'hFF, 1'b1, err);
      chk(err, "R8 op write while busy errors", err, 1);
      @(negedge clk);
      reg_rd_addr = 12'h7FC;
      #1 chk(reg_rd_data == 32'h04, "R8 mask unchanged", reg_rd_data, 32'h04);
      reg_write(12'h700, 32'h1, 1'b0, err);
      chk(err, "R8 other write while busy errors", err, 1);
      wait_idle(cyc);
      chk(wb_cnt == NS, "R9 all dirty lines handed off", wb_cnt, NS);
      peek(15, 2, st);
      chk(st == 3'b101, "R3 locked way cleaned, valid kept", st, 3'b101);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule